// File: doc/BRIEF.md
# Sticky Fault Status and Mask Unit

This block sits between the fault detectors of a two-phase power converter controller and its protection sequencer. Each of ten detectors delivers a one-cycle event pulse. Every pulse is latched into a 16-bit status word, and the bit stays set until software or a reset removes it. A second 16-bit word, the mask, decides which of the eight true faults may stop the converter. A masked fault is still recorded in the status word, but switching carries on as normal.

Software reaches both words through a plain word-wide register port that has an address, a write enable, write data and combinational read data. A status bit is cleared by writing 0 to its position. A single-cycle clear-all strobe wipes the whole status word. When an unmasked fault fires, the block raises a protect request one cycle later. Alongside it the block gives the response mode, hiccup or latch-off, taken from a per-fault configuration input. Here latch-off wins whenever any of the faults that fired selects it.

Top module: `fault_latch_guard`

## Requirements
- R1: After a synchronous reset the status word reads 0000h, the mask word reads 0049h, and protect_req and protect_mode are 0.
- R2: An event pulse on evt[i] sets status bit i on the next clock edge, whatever the mask holds. The status layout is: bit 9 PLL lock, 8 PLL compensation short, 7 output overvoltage, 6 output undervoltage, 5 peak overcurrent, 4 average overcurrent, 3 over-temperature fault, 2 input overvoltage, 1 over-temperature warning, 0 communication/memory/logic warning.
- R3: A set status bit stays at 1 as long as no status write and no clear-all occur.
- R4: A write to address 0 (status) clears each status bit where the written data holds 0, and leaves unchanged each bit where the data holds 1.
- R5: A one-cycle pulse on clr_all makes every status bit 0 on the following clock edge.
- R6: If an event pulse and a clearing action (a status write of 0 or clr_all) reach the same bit in the same cycle, the bit ends up at 1.
- R7: Status bits 15:10 always read 0.
- R8: A write to address 1 (mask) stores data bits 9:0. Mask bits 15:10 ignore writes and read 0.
- R9: One cycle after a pulse on any evt[i], i in 9..2, whose mask bit is 0, protect_req is 1. protect_req is 0 in the cycle after a cycle that has no such pulse.
- R10: The warning events evt[1:0] never raise protect_req, whatever mask bits 1:0 hold.
- R11: protect_mode (1 = latch-off, 0 = hiccup) is 1 exactly when resp_sel[i] is 1 for at least one unmasked fault i in 9..2 that fired in the previous cycle. It is 0 whenever protect_req is 0.
- R12: Reads from addresses 2 and 3 return 0, and writes to them change neither word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| evt | input | 10 | One-cycle fault and warning event pulses, bit i maps to status bit i |
| reg_addr | input | 2 | Register address: 0 status, 1 mask |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational read data for reg_addr |
| clr_all | input | 1 | Clear-all-faults strobe, one cycle |
| resp_sel | input | 10 | Per-fault response mode, 1 latch-off, 0 hiccup |
| protect_req | output | 1 | Registered protective-action request |
| protect_mode | output | 1 | Registered response mode for the request, 1 latch-off |

## Verification
The hardest situation to reach from the ports is a conflict in one cycle: a fault pulse arrives on the very edge where a clearing write or the clear-all strobe takes effect. The stimulus therefore builds a known status pattern first. It then drives an event together with a status write of all zeros, and later together with clr_all. Reading the status back shows that only the fresh event bit survived. A second delicate case is a masked fault, which must be recorded but must not raise the request. It is reached by firing a fault that the reset mask already suppresses and then reading the status word.

// File: rtl/fault_latch_pkg.sv
package fault_latch_pkg;

    parameter int REG_W   = 16;
    parameter int EVT_N   = 10;
    parameter int WARN_N  = 2;
    parameter int ADDR_W  = 2;

    localparam int PAD_W = REG_W - EVT_N;

    localparam logic [ADDR_W-1:0] ADR_STATUS = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADR_MASK   = ADDR_W'(1);

    localparam logic [REG_W-1:0] MASK_RST = 16'h0049;

    typedef enum logic {
        RESP_HICCUP   = 1'b0,
        RESP_LATCHOFF = 1'b1
    } resp_e;

    typedef struct packed {
        logic             wr_stat;
        logic             wr_mask;
        logic [REG_W-1:0] data;
    } regwr_t;

    function automatic logic [REG_W-1:0] widen(input logic [EVT_N-1:0] v);
        return {{PAD_W{1'b0}}, v};
    endfunction

    function automatic logic [REG_W-1:0] live_bits();
        return {{PAD_W{1'b0}}, {EVT_N{1'b1}}};
    endfunction

endpackage

// File: rtl/flg_decode.sv
module flg_decode
    import fault_latch_pkg::*;
(
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [REG_W-1:0]  status_q,
    input  logic [REG_W-1:0]  mask_q,
    output regwr_t            wr,
    output logic [REG_W-1:0]  rdata
);

    always_comb begin
        wr.wr_stat = reg_we && (reg_addr == ADR_STATUS);
        wr.wr_mask = reg_we && (reg_addr == ADR_MASK);
        wr.data    = reg_wdata;
    end

    always_comb begin
        unique case (reg_addr)
            ADR_STATUS: rdata = status_q;
            ADR_MASK:   rdata = mask_q;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/flg_status.sv
module flg_status
    import fault_latch_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_N-1:0] evt,
    input  logic             clr_all,
    input  regwr_t           wr,
    output logic [REG_W-1:0] status_q
);

    logic [REG_W-1:0] evt_w;
    logic [REG_W-1:0] kept;
    logic [REG_W-1:0] status_d;

    always_comb begin
        evt_w = widen(evt);
        if (clr_all)
            kept = '0;
        else if (wr.wr_stat)
            kept = status_q & wr.data;
        else
            kept = status_q;
        status_d = (kept | evt_w) & live_bits();
    end

    always_ff @(posedge clk) begin
        if (rst)
            status_q <= '0;
        else
            status_q <= status_d;
    end

    // R2: an event is always recorded on the next edge
    a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & $past(widen(evt))) == $past(widen(evt))));

    // R3: without clearing, set bits persist
    a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
        (!clr_all && !wr.wr_stat) |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R5: clear-all with no event empties the word
    a_r5_clear_all: assert property (@(posedge clk) disable iff (rst)
        (clr_all && evt == '0) |=> (status_q == '0));

    // R7: upper bits never set
    a_r7_unused_zero: assert property (@(posedge clk) disable iff (rst)
        (status_q[REG_W-1:EVT_N] == '0));

endmodule

// File: rtl/flg_mask.sv
module flg_mask
    import fault_latch_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  regwr_t           wr,
    output logic [REG_W-1:0] mask_q
);

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= MASK_RST;
        else if (wr.wr_mask)
            mask_q <= wr.data & live_bits();
    end

    // R8: bits above the event range stay zero
    a_r8_mask_unused: assert property (@(posedge clk) disable iff (rst)
        (mask_q[REG_W-1:EVT_N] == '0));

    // R8: without a mask write the mask holds
    a_r8_mask_hold: assert property (@(posedge clk) disable iff (rst)
        !wr.wr_mask |=> $stable(mask_q));

endmodule

// File: rtl/flg_protect.sv
module flg_protect
    import fault_latch_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_N-1:0] evt,
    input  logic [REG_W-1:0] mask_q,
    input  logic [EVT_N-1:0] resp_sel,
    output logic             protect_req,
    output resp_e            protect_mode
);

    logic [EVT_N-1:0] fired;

    for (genvar g = 0; g < EVT_N; g++) begin : g_fire
        if (g < WARN_N) begin : g_warn
            assign fired[g] = 1'b0;
        end else begin : g_fault
            assign fired[g] = evt[g] & ~mask_q[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            protect_req  <= 1'b0;
            protect_mode <= RESP_HICCUP;
        end else begin
            protect_req  <= |fired;
            protect_mode <= (|(fired & resp_sel)) ? RESP_LATCHOFF : RESP_HICCUP;
        end
    end

    // R9: a cycle with no unmasked fault yields no request
    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        ((evt[EVT_N-1:WARN_N] & ~mask_q[EVT_N-1:WARN_N]) == '0) |=> !protect_req);

    // R10: warnings alone never request protection
    a_r10_warn_quiet: assert property (@(posedge clk) disable iff (rst)
        (evt[EVT_N-1:WARN_N] == '0) |=> !protect_req);

    // R11: latch-off only accompanies a request
    a_r11_mode_with_req: assert property (@(posedge clk) disable iff (rst)
        (protect_mode == RESP_LATCHOFF) |-> protect_req);

endmodule

// File: rtl/fault_latch_guard.sv
module fault_latch_guard
    import fault_latch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [EVT_N-1:0]  evt,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              clr_all,
    input  logic [EVT_N-1:0]  resp_sel,
    output logic              protect_req,
    output logic              protect_mode
);

    regwr_t           wr;
    logic [REG_W-1:0] status_q;
    logic [REG_W-1:0] mask_q;
    resp_e            mode_e;

    flg_decode u_decode (
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .status_q  (status_q),
        .mask_q    (mask_q),
        .wr        (wr),
        .rdata     (reg_rdata)
    );

    flg_status u_status (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .clr_all  (clr_all),
        .wr       (wr),
        .status_q (status_q)
    );

    flg_mask u_mask (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .mask_q (mask_q)
    );

    flg_protect u_protect (
        .clk          (clk),
        .rst          (rst),
        .evt          (evt),
        .mask_q       (mask_q),
        .resp_sel     (resp_sel),
        .protect_req  (protect_req),
        .protect_mode (mode_e)
    );

    assign protect_mode = (mode_e == RESP_LATCHOFF);

    // R12: writes to unmapped addresses touch neither word
    a_r12_unmapped: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr != ADR_STATUS && reg_addr != ADR_MASK && evt == '0 && !clr_all)
        |=> ($stable(status_q) && $stable(mask_q)));

endmodule

// File: tb/test_fault_latch_guard.sv
module test_fault_latch_guard;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  evt = '0;
    logic [1:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        clr_all = 1'b0;
    logic [9:0]  resp_sel = '0;
    logic        protect_req;
    logic        protect_mode;

    always #4 clk = ~clk;

    fault_latch_guard i_fault_latch_guard (
        .clk          (clk),
        .rst          (rst),
        .evt          (evt),
        .reg_addr     (reg_addr),
        .reg_we       (reg_we),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .clr_all      (clr_all),
        .resp_sel     (resp_sel),
        .protect_req  (protect_req),
        .protect_mode (protect_mode)
    );

    typedef struct {
        logic        chk_rd;
        logic [15:0] rd;
        logic        prot;
        logic        mode;
        string       tag;
    } exp_t;

    exp_t        q[$];
    int          n_run  = 0;
    int          n_fail = 0;
    logic [15:0] m_status = 16'h0000;
    logic [15:0] m_mask   = 16'h0049;
    bit          done = 0;

    function automatic logic [15:0] model_read(input logic [1:0] a);
        if (a == 2'd0) return m_status;
        if (a == 2'd1) return m_mask;
        return 16'h0000;
    endfunction

    task automatic step(input logic [9:0] e, input logic we, input logic [1:0] a,
                        input logic [15:0] wd, input logic clr, input logic [9:0] cfg,
                        input logic chk, input string tag);
        exp_t        it;
        logic [9:0]  hit;
        @(negedge clk);
        evt = e; reg_we = we; reg_addr = a; reg_wdata = wd; clr_all = clr; resp_sel = cfg;
        hit = e & ~m_mask[9:0] & 10'b1111111100;
        it.prot = |hit;
        it.mode = |(hit & cfg);
        if (clr) m_status = 16'h0000;
        else if (we && a == 2'd0) m_status = m_status & wd;
        m_status = m_status | {6'b0, e};
        if (we && a == 2'd1) m_mask = wd & 16'h03FF;
        it.chk_rd = chk;
        it.rd     = model_read(a);
        it.tag    = tag;
        q.push_back(it);
    endtask

    task automatic rd(input logic [1:0] a, input string tag);
        step('0, 1'b0, a, 16'h0, 1'b0, '0, 1'b1, tag);
    endtask

    initial begin : monitor
        exp_t it;
        wait (!rst);
        forever begin
            @(posedge clk); #2;
            if (q.size() > 0) begin
                it = q.pop_front();
                n_run++;
                if (protect_req !== it.prot || protect_mode !== it.mode) begin
                    n_fail++;
                    $display("FAIL %s protect actual=%b/%b expected=%b/%b",
                             it.tag, protect_req, protect_mode, it.prot, it.mode);
                end
                if (it.chk_rd) begin
                    n_run++;
                    if (reg_rdata !== it.rd) begin
                        n_fail++;
                        $display("FAIL %s rdata actual=%h expected=%h", it.tag, reg_rdata, it.rd);
                    end
                end
            end
        end
    end

    initial begin : watchdog
        #(8 * 100000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset values
        rd(2'd0, "R1 status");
        rd(2'd1, "R1 mask");
        // R12 unmapped read
        rd(2'd2, "R12 read");
        // R2 R9 unmasked overvoltage fault, hiccup
        step(10'h080, 1'b0, 2'd0, 16'h0, 1'b0, '0, 1'b0, "R9 R11 fire bit7");
        rd(2'd0, "R2 bit7 set");
        // R3 sticky across idle cycles
        step('0, 1'b0, 2'd0, 16'h0, 1'b0, '0, 1'b0, "R3 idle");
        step('0, 1'b0, 2'd0, 16'h0, 1'b0, '0, 1'b0, "R3 idle");
        rd(2'd0, "R3 sticky");
        // R2 R9 masked fault (bit3 masked at reset) still recorded
        step(10'h008, 1'b0, 2'd0, 16'h0, 1'b0, '1, 1'b0, "R9 masked bit3");
        rd(2'd0, "R2 masked recorded");
        // R8 mask write, upper bits dropped
        step('0, 1'b1, 2'd1, 16'hFFFF, 1'b0, '0, 1'b0, "R8 mask write");
        rd(2'd1, "R8 mask read");
        step('0, 1'b1, 2'd1, 16'h0000, 1'b0, '0, 1'b0, "R8 mask zero");
        rd(2'd1, "R8 mask zero read");
        // R10 warnings with mask zero
        step(10'h003, 1'b0, 2'd0, 16'h0, 1'b0, '1, 1'b0, "R10 warnings");
        rd(2'd0, "R10 R2 warnings recorded");
        // R4 write ones: no change; write zero in bit7: cleared
        step('0, 1'b1, 2'd0, 16'hFFFF, 1'b0, '0, 1'b0, "R4 write ones");
        rd(2'd0, "R4 ones keep");
        step('0, 1'b1, 2'd0, 16'hFF7F, 1'b0, '0, 1'b0, "R4 clear bit7");
        rd(2'd0, "R4 bit7 cleared");
        // R7 upper bits read zero
        rd(2'd0, "R7 upper zero");
        // R6 event beats clearing write
        step(10'h020, 1'b1, 2'd0, 16'h0000, 1'b0, '0, 1'b0, "R6 event vs write");
        rd(2'd0, "R6 bit5 survives");
        // R5 clear all
        step(10'h003, 1'b0, 2'd0, 16'h0, 1'b0, '0, 1'b0, "R5 prep");
        step('0, 1'b0, 2'd0, 16'h0, 1'b1, '0, 1'b0, "R5 clear");
        rd(2'd0, "R5 cleared");
        // R6 event beats clear-all
        step(10'h044, 1'b0, 2'd0, 16'h0, 1'b0, '0, 1'b0, "R6 prep");
        step(10'h200, 1'b0, 2'd0, 16'h0, 1'b1, '0, 1'b0, "R6 event vs clr_all");
        rd(2'd0, "R6 bit9 survives");
        // R11 latch-off selection
        step(10'h050, 1'b0, 2'd0, 16'h0, 1'b0, 10'h040, 1'b0, "R11 latch wins");
        step(10'h010, 1'b0, 2'd0, 16'h0, 1'b0, 10'h040, 1'b0, "R11 hiccup only");
        step(10'h004, 1'b0, 2'd0, 16'h0, 1'b0, 10'h004, 1'b0, "R11 latch bit2");
        // R12 unmapped writes ignored
        step('0, 1'b1, 2'd2, 16'hFFFF, 1'b0, '0, 1'b0, "R12 write addr2");
        step('0, 1'b1, 2'd3, 16'h0000, 1'b0, '0, 1'b0, "R12 write addr3");
        rd(2'd1, "R12 mask intact");
        rd(2'd0, "R12 status intact");
        rd(2'd3, "R12 read addr3");
        step('0, 1'b0, 2'd0, 16'h0, 1'b0, '0, 1'b0, "R9 quiet");
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule